// File: doc/BRIEF.md
# Selectable Fixed-Mapping Address Translator

This block turns 32-bit virtual addresses into physical addresses for a core that may have no translation lookaside buffer. A two-bit MMU-type input chooses one of three behaviours. Identity mode passes every address through unchanged. Fixed mode applies a segment-based mapping. TLB mode translates the unmapped kernel window itself and flags every other address for lookup in an external TLB. The type is captured while reset is held and stays fixed until the next reset, so the core cannot change translation style while it is running.

Each request is answered one clock later with a valid pulse and registered results: the physical address, read and write permission, and a flag that requests a TLB lookup. A separate one-hot strobe carries the four TLB management instructions. If any of them arrives while no TLB is selected, the block raises a reserved-instruction pulse so that the core can take the exception. Selecting the reserved type raises a configuration-error flag that stays high.

Top module: `addr_xlate_top`

## Requirements
- R1: The MMU type is loaded from `mmu_type_i` on every clock edge at which `rst` is high. After reset it is held, and later changes on `mmu_type_i` have no effect on translation.
- R2: Type 0 (none): `paddr_o` equals the requested virtual address.
- R3: Type 3 (fixed): a virtual address below 0x80000000 with `erl_i` low translates to the address plus 0x40000000.
- R4: Type 3: a virtual address below 0x80000000 with `erl_i` high translates unchanged.
- R5: Type 3: a virtual address from 0x80000000 to 0xBFFFFFFF translates to the address ANDed with 0x1FFFFFFF.
- R6: Type 3: a virtual address at or above 0xC0000000 translates unchanged.
- R7: In types 0 and 3, every response has `rd_ok_o` and `wr_ok_o` high and `tlb_lookup_o` low.
- R8: Type 1 (TLB): an address below 0x80000000 with `erl_i` low, or any address at or above 0xC0000000, gives `tlb_lookup_o` high, both permissions low and `paddr_o` equal to the virtual address.
- R9: Type 1: an address from 0x80000000 to 0xBFFFFFFF translates to the address ANDed with 0x1FFFFFFF. An address below 0x80000000 with `erl_i` high translates unchanged. In both cases both permissions are granted and no lookup is requested.
- R10: Type 2 is reserved. `cfg_err_o` is high after reset in this type and low in every other type. In type 2, responses carry both permissions low, no lookup, and `paddr_o` equal to the virtual address.
- R11: `tlb_op_i` is one-hot, with bit 0 = write-indexed, bit 1 = write-random, bit 2 = probe and bit 3 = read. Any bit set produces a one-cycle `rsvd_instr_o` pulse on the next cycle when the type is not 1. When the type is 1, no pulse is produced.
- R12: `vld_o` is high exactly one cycle after a cycle with `req_i` high. Without a request, `paddr_o` and the flags hold their values.
- R13: While `rst` is high, all outputs other than `cfg_err_o` are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; MMU type is loaded while high |
| mmu_type_i | input | 2 | Translation style: 0 none, 1 TLB, 2 reserved, 3 fixed |
| req_i | input | 1 | Translation request strobe |
| vaddr_i | input | 32 | Virtual address |
| erl_i | input | 1 | Error-level status bit |
| tlb_op_i | input | 4 | One-hot TLB management instruction strobe |
| vld_o | output | 1 | Response valid, one cycle after request |
| paddr_o | output | 32 | Physical address |
| rd_ok_o | output | 1 | Read permitted |
| wr_ok_o | output | 1 | Write permitted |
| tlb_lookup_o | output | 1 | Address must be resolved by the external TLB |
| rsvd_instr_o | output | 1 | Reserved-instruction pulse for a rejected TLB operation |
| cfg_err_o | output | 1 | Unsupported MMU type selected |

## Verification
The bench runs every MMU type and sweeps all 256 values of the top address byte with both error-level settings, so every segment boundary (0x7F/0x80, 0xBF/0xC0) is crossed. A design that compared against the wrong boundary would misplace those pages, and a design that wrapped the low-segment offset incorrectly would corrupt 0x7FFFFFFF. Each of the four TLB operation bits is sent in every type. A guard that tested only one bit, or that also rejected in TLB mode, would show a wrong reserved-instruction pulse. The type input is changed after reset to catch a design that re-samples it, and idle cycles check that the results hold rather than follow the address bus.

// File: rtl/addr_xlate_pkg.sv
package addr_xlate_pkg;

  typedef enum logic [1:0] {
    MMU_NONE  = 2'd0,
    MMU_TLB   = 2'd1,
    MMU_RSVD  = 2'd2,
    MMU_FIXED = 2'd3
  } mmu_mode_e;

  typedef enum logic [1:0] {
    SEG_LOW    = 2'd0,
    SEG_DIRECT = 2'd1,
    SEG_HIGH   = 2'd2
  } seg_e;

  typedef struct packed {
    logic rd;
    logic wr;
    logic lookup;
  } xl_flags_t;

endpackage

// File: rtl/xlate_mode_latch.sv
module xlate_mode_latch
  import addr_xlate_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] type_i,
  output mmu_mode_e  mode_o,
  output logic       cfg_err_o
);

  mmu_mode_e mode_q;
  logic      cfg_err_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      mode_q    <= mmu_mode_e'(type_i);
      cfg_err_q <= (type_i == 2'd2);
    end
  end

  assign mode_o    = mode_q;
  assign cfg_err_o = cfg_err_q;

  // R1: outside reset the captured type never moves
  a_r1_mode_held: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(mode_q));

  // R1: the error flag is held together with the type
  a_r1_cfg_held: assert property (@(posedge clk) disable iff (rst)
    !rst |=> $stable(cfg_err_q));

endmodule

// File: rtl/xlate_seg_decode.sv
module xlate_seg_decode
  import addr_xlate_pkg::*;
(
  input  logic [1:0] top2_i,
  output seg_e       seg_o
);

  always_comb begin
    unique case (top2_i)
      2'b10:   seg_o = SEG_DIRECT;
      2'b11:   seg_o = SEG_HIGH;
      default: seg_o = SEG_LOW;
    endcase
  end

endmodule

// File: rtl/xlate_map_core.sv
module xlate_map_core
  import addr_xlate_pkg::*;
#(
  parameter int ADDR_W = 32
) (
  input  mmu_mode_e         mode_i,
  input  seg_e              seg_i,
  input  logic [ADDR_W-1:0] va_i,
  input  logic              erl_i,
  output logic [ADDR_W-1:0] pa_o,
  output xl_flags_t         fl_o
);

  localparam logic [ADDR_W-1:0] LOW_OFS     = {2'b01, {(ADDR_W-2){1'b0}}};
  localparam logic [ADDR_W-1:0] DIRECT_MASK = {3'b000, {(ADDR_W-3){1'b1}}};

  always_comb begin
    pa_o = va_i;
    fl_o = '{rd: 1'b1, wr: 1'b1, lookup: 1'b0};
    unique case (mode_i)
      MMU_FIXED: begin
        case (seg_i)
          SEG_LOW:    if (!erl_i) pa_o = va_i + LOW_OFS;
          SEG_DIRECT: pa_o = va_i & DIRECT_MASK;
          default:    pa_o = va_i;
        endcase
      end
      MMU_TLB: begin
        case (seg_i)
          SEG_LOW:    if (!erl_i) fl_o = '{rd: 1'b0, wr: 1'b0, lookup: 1'b1};
          SEG_DIRECT: pa_o = va_i & DIRECT_MASK;
          default:    fl_o = '{rd: 1'b0, wr: 1'b0, lookup: 1'b1};
        endcase
      end
      MMU_RSVD: fl_o = '{rd: 1'b0, wr: 1'b0, lookup: 1'b0};
      default:  pa_o = va_i;
    endcase
  end

endmodule

// File: rtl/xlate_tlbop_guard.sv
module xlate_tlbop_guard
  import addr_xlate_pkg::*;
#(
  parameter int TLB_OPS = 4
) (
  input  mmu_mode_e          mode_i,
  input  logic [TLB_OPS-1:0] op_i,
  output logic               reject_o
);

  assign reject_o = (|op_i) && (mode_i != MMU_TLB);

endmodule

// File: rtl/addr_xlate_top.sv
module addr_xlate_top
  import addr_xlate_pkg::*;
#(
  parameter int ADDR_W  = 32,
  parameter int TLB_OPS = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [1:0]         mmu_type_i,
  input  logic               req_i,
  input  logic [ADDR_W-1:0]  vaddr_i,
  input  logic               erl_i,
  input  logic [TLB_OPS-1:0] tlb_op_i,
  output logic               vld_o,
  output logic [ADDR_W-1:0]  paddr_o,
  output logic               rd_ok_o,
  output logic               wr_ok_o,
  output logic               tlb_lookup_o,
  output logic               rsvd_instr_o,
  output logic               cfg_err_o
);

  localparam logic [ADDR_W-1:0] LOW_OFS = {2'b01, {(ADDR_W-2){1'b0}}};

  mmu_mode_e         mode;
  seg_e              seg;
  logic [ADDR_W-1:0] pa_next;
  xl_flags_t         fl_next;
  logic              reject;

  xlate_mode_latch u_mode (
    .clk       (clk),
    .rst       (rst),
    .type_i    (mmu_type_i),
    .mode_o    (mode),
    .cfg_err_o (cfg_err_o)
  );

  xlate_seg_decode u_seg (
    .top2_i (vaddr_i[ADDR_W-1:ADDR_W-2]),
    .seg_o  (seg)
  );

  xlate_map_core #(.ADDR_W(ADDR_W)) u_map (
    .mode_i (mode),
    .seg_i  (seg),
    .va_i   (vaddr_i),
    .erl_i  (erl_i),
    .pa_o   (pa_next),
    .fl_o   (fl_next)
  );

  xlate_tlbop_guard #(.TLB_OPS(TLB_OPS)) u_guard (
    .mode_i   (mode),
    .op_i     (tlb_op_i),
    .reject_o (reject)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      vld_o        <= 1'b0;
      paddr_o      <= '0;
      rd_ok_o      <= 1'b0;
      wr_ok_o      <= 1'b0;
      tlb_lookup_o <= 1'b0;
      rsvd_instr_o <= 1'b0;
    end else begin
      vld_o        <= req_i;
      rsvd_instr_o <= reject;
      if (req_i) begin
        paddr_o      <= pa_next;
        rd_ok_o      <= fl_next.rd;
        wr_ok_o      <= fl_next.wr;
        tlb_lookup_o <= fl_next.lookup;
      end
    end
  end

  // R2: identity mode returns the requested address
  a_r2_identity: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && vld_o && mode == MMU_NONE) |-> paddr_o == $past(vaddr_i));

  // R3: fixed low segment with error level clear is offset
  a_r3_low_offset: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && vld_o && mode == MMU_FIXED && !$past(vaddr_i[ADDR_W-1]) && !$past(erl_i))
      |-> paddr_o == $past(vaddr_i) + LOW_OFS);

  // R7: no-TLB styles always grant access and never miss
  a_r7_never_miss: assert property (@(posedge clk) disable iff (rst)
    (vld_o && (mode == MMU_NONE || mode == MMU_FIXED)) |-> (rd_ok_o && wr_ok_o && !tlb_lookup_o));

  // R8: a lookup request only happens in TLB mode and carries no permission
  a_r8_lookup_no_perm: assert property (@(posedge clk) disable iff (rst)
    tlb_lookup_o |-> (mode == MMU_TLB && !rd_ok_o && !wr_ok_o));

  // R10: the reserved type never grants or delegates
  a_r10_cfg_err_quiet: assert property (@(posedge clk) disable iff (rst)
    (vld_o && cfg_err_o) |-> (!rd_ok_o && !wr_ok_o && !tlb_lookup_o));

  // R11: a TLB operation without a TLB is flagged one cycle later
  a_r11_reject: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(|tlb_op_i) && mode != MMU_TLB) |-> rsvd_instr_o);

  // R11: TLB mode never flags a TLB operation
  a_r11_tlb_accepts: assert property (@(posedge clk) disable iff (rst)
    rsvd_instr_o |-> mode != MMU_TLB);

  // R12: a response follows every request
  a_r12_valid_follows: assert property (@(posedge clk) disable iff (rst)
    req_i |=> vld_o);

  // R12: results hold while idle
  a_r12_hold: assert property (@(posedge clk) disable iff (rst)
    !req_i |=> ($stable(paddr_o) && !vld_o));

endmodule

// File: tb/tb_addr_xlate_top.sv
`timescale 1ns/1ps
module tb_addr_xlate_top;

  localparam int AW = 32;
  localparam time PERIOD = 20ns;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [1:0]    mmu_type_i = 2'd0;
  logic          req_i = 1'b0;
  logic [AW-1:0] vaddr_i = '0;
  logic          erl_i = 1'b0;
  logic [3:0]    tlb_op_i = '0;
  logic          vld_o, rd_ok_o, wr_ok_o, tlb_lookup_o, rsvd_instr_o, cfg_err_o;
  logic [AW-1:0] paddr_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(PERIOD/2) clk = ~clk;

  addr_xlate_top #(.ADDR_W(AW), .TLB_OPS(4)) dut (
    .clk(clk), .rst(rst), .mmu_type_i(mmu_type_i), .req_i(req_i),
    .vaddr_i(vaddr_i), .erl_i(erl_i), .tlb_op_i(tlb_op_i),
    .vld_o(vld_o), .paddr_o(paddr_o), .rd_ok_o(rd_ok_o), .wr_ok_o(wr_ok_o),
    .tlb_lookup_o(tlb_lookup_o), .rsvd_instr_o(rsvd_instr_o), .cfg_err_o(cfg_err_o)
  );

  task automatic chk(input bit ok, input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", rq, act, exp);
    end
  endtask

  // Expected translation computed from the requirements
  task automatic model(input int mode, input logic [31:0] va, input bit erl,
                       output logic [31:0] pa, output bit rd, output bit wr, output bit lk,
                       output string tag_pa, output string tag_fl);
    pa = va; rd = 1; wr = 1; lk = 0;
    case (mode)
      0: begin tag_pa = "R2"; tag_fl = "R7"; end
      3: begin
        tag_fl = "R7";
        if (va < 32'h8000_0000) begin
          if (erl) tag_pa = "R4";
          else begin pa = va + 32'h4000_0000; tag_pa = "R3"; end
        end else if (va < 32'hC000_0000) begin
          pa = va & 32'h1FFF_FFFF; tag_pa = "R5";
        end else tag_pa = "R6";
      end
      1: begin
        if ((va < 32'h8000_0000 && !erl) || va >= 32'hC000_0000) begin
          rd = 0; wr = 0; lk = 1; tag_pa = "R8"; tag_fl = "R8";
        end else begin
          if (va >= 32'h8000_0000) pa = va & 32'h1FFF_FFFF;
          tag_pa = "R9"; tag_fl = "R9";
        end
      end
      default: begin rd = 0; wr = 0; tag_pa = "R10"; tag_fl = "R10"; end
    endcase
  endtask

  task automatic do_reset(input int mode);
    @(negedge clk);
    rst = 1'b1; mmu_type_i = 2'(mode); req_i = 1'b1; tlb_op_i = 4'hF;
    vaddr_i = 32'hDEAD_BEEF;
    @(negedge clk);
    @(negedge clk);
    chk(!vld_o && paddr_o == 0 && !rd_ok_o && !wr_ok_o && !tlb_lookup_o && !rsvd_instr_o,
        "R13", {26'd0, vld_o, rd_ok_o, wr_ok_o, tlb_lookup_o, rsvd_instr_o, |paddr_o}, 32'd0);
    rst = 1'b0; req_i = 1'b0; tlb_op_i = '0;
    @(negedge clk);
    chk(cfg_err_o == (mode == 2), "R10", {31'd0, cfg_err_o}, {31'd0, mode == 2});
  endtask

  // Drives one request at a falling edge and checks it at the next falling edge
  task automatic xact(input int mode, input logic [31:0] va, input bit erl);
    logic [31:0] pa; bit rd, wr, lk; string tp, tf;
    model(mode, va, erl, pa, rd, wr, lk, tp, tf);
    req_i = 1'b1; vaddr_i = va; erl_i = erl;
    @(negedge clk);
    req_i = 1'b0;
    chk(vld_o, "R12", {31'd0, vld_o}, 32'd1);
    chk(paddr_o == pa, tp, paddr_o, pa);
    chk({rd_ok_o, wr_ok_o, tlb_lookup_o} == {rd, wr, lk}, tf,
        {29'd0, rd_ok_o, wr_ok_o, tlb_lookup_o}, {29'd0, rd, wr, lk});
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    for (int m = 0; m < 4; m++) begin
      do_reset(m);
      for (int hi = 0; hi < 256; hi++) begin
        for (int e = 0; e < 2; e++) begin
          xact(m, {8'(hi), 24'hA5_5A3C}, e[0]);
          xact(m, {8'(hi), 24'hFF_FFFF}, e[0]);
        end
      end
      // R12: idle cycle holds result and drops valid
      begin
        logic [31:0] held;
        held = paddr_o;
        vaddr_i = ~vaddr_i; erl_i = ~erl_i;
        @(negedge clk);
        chk(!vld_o && paddr_o == held, "R12", paddr_o, held);
      end
      // R11: every TLB operation bit in this type
      for (int k = 0; k < 4; k++) begin
        tlb_op_i = 4'(1 << k);
        @(negedge clk);
        tlb_op_i = '0;
        chk(rsvd_instr_o == (m != 1), "R11", {31'd0, rsvd_instr_o}, {31'd0, m != 1});
        @(negedge clk);
        chk(!rsvd_instr_o, "R11", {31'd0, rsvd_instr_o}, 32'd0);
      end
      chk(cfg_err_o == (m == 2), "R10", {31'd0, cfg_err_o}, {31'd0, m == 2});
    end
    // R1: type changes after reset are ignored
    do_reset(3);
    mmu_type_i = 2'd0;
    @(negedge clk);
    xact(3, 32'h1234_5678, 1'b0);
    mmu_type_i = 2'd1;
    @(negedge clk);
    req_i = 1'b1; vaddr_i = 32'hC000_1000; erl_i = 1'b0;
    @(negedge clk);
    req_i = 1'b0;
    chk(!tlb_lookup_o && rd_ok_o && paddr_o == 32'hC000_1000, "R1", paddr_o, 32'hC000_1000);
    tlb_op_i = 4'b0100;
    @(negedge clk);
    tlb_op_i = '0;
    chk(rsvd_instr_o, "R1", {31'd0, rsvd_instr_o}, 32'd1);
    mmu_type_i = 2'd2;
    @(negedge clk);
    chk(!cfg_err_o, "R1", {31'd0, cfg_err_o}, 32'd0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule